// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block maps a 20-bit virtual page number, qualified by a 6-bit address-space identifier, to a 20-bit physical frame number with cacheability, dirty, valid and global attributes. It holds a parameterized number of entries (64 by default), and it compares every entry in parallel on each translation request. It accepts one request per cycle and returns the result one cycle later. A failed or unusable translation appears only as a flag.

Software reaches the entries through two staging registers: a high half (page number and identifier) and a low half (frame number and attribute bits). An index pointer selects the entry for indexed reads and writes. A free-running replacement pointer chooses the slot for random writes, and it never selects the reserved low entries. A probe searches all entries for the staged high half and leaves the matching entry number in the index pointer. Translation requests are matched against the identifier currently held in the staging high half.

Top module: `tlbx_top`

## Requirements
- R1: Operation codes are 0 for read-indexed, 1 for write-indexed, 2 for write-random and 3 for probe. A write-indexed operation stores both staging halves into the entry named by the index pointer. A later read-indexed operation loads that entry back into both staging halves, which are visible on the outputs after the next clock edge.
- R2: A translation request hits an entry when the page numbers are equal and either the entry's global bit is set or its identifier equals the staged identifier. One cycle after the request, the response carries that entry's frame number and non-cacheable bit. When several entries match, the lowest-numbered one is used.
- R3: One cycle after a request for which no entry matches, the miss flag is raised, and the invalid and modify flags stay low.
- R4: The replacement pointer reads 63 during reset. It decrements once per clock, reloads 63 after it has shown 8, and never shows a value below 8.
- R5: A write-random operation stores the staging halves at the entry shown by the replacement pointer in that cycle. Entries 0 to 7 are never written by it.
- R6: A probe that finds a match loads the lowest matching entry number into the index pointer and clears the probe-fail bit. The valid bit of the entry plays no part in a probe.
- R7: A probe that finds no match sets the probe-fail bit and leaves the index pointer's value unchanged.
- R8: When a request matches an entry whose valid bit is clear, the invalid flag is raised one cycle later, and the miss and modify flags stay low.
- R9: When a store request matches a valid entry whose dirty bit is clear, the modify flag is raised one cycle later. A load request, or a store to a dirty entry, raises no flag.
- R10: A software write of the index pointer loads the written value and clears the probe-fail bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_hi_we | input | 1 | Load the staging high half |
| stg_hi_vpn | input | 20 | Page number for the staging high half |
| stg_hi_asid | input | 6 | Identifier for the staging high half |
| stg_lo_we | input | 1 | Load the staging low half |
| stg_lo_pfn | input | 20 | Frame number for the staging low half |
| stg_lo_nc | input | 1 | Non-cacheable bit |
| stg_lo_dirty | input | 1 | Dirty (writable) bit |
| stg_lo_valid | input | 1 | Valid bit |
| stg_lo_glob | input | 1 | Global bit (identifier ignored) |
| ptr_we | input | 1 | Software write of the index pointer |
| ptr_wdata | input | 6 | New index pointer value |
| op_valid | input | 1 | Perform an operation this cycle |
| op_code | input | 2 | Operation code (see R1) |
| lk_valid | input | 1 | Translation request |
| lk_vpn | input | 20 | Page number to translate |
| lk_store | input | 1 | Request is a store |
| hi_vpn_o | output | 20 | Staged page number |
| hi_asid_o | output | 6 | Staged identifier |
| lo_pfn_o | output | 20 | Staged frame number |
| lo_nc_o | output | 1 | Staged non-cacheable bit |
| lo_dirty_o | output | 1 | Staged dirty bit |
| lo_valid_o | output | 1 | Staged valid bit |
| lo_glob_o | output | 1 | Staged global bit |
| ptr_o | output | 6 | Index pointer |
| probe_fail_o | output | 1 | Last probe found nothing |
| rnd_o | output | 6 | Replacement pointer |
| rsp_valid_o | output | 1 | Translation response valid |
| rsp_pfn_o | output | 20 | Translated frame number |
| rsp_nc_o | output | 1 | Translated non-cacheable bit |
| rsp_miss_o | output | 1 | No entry matched |
| rsp_inv_o | output | 1 | Matched entry is invalid |
| rsp_mod_o | output | 1 | Store to a clean entry |

## Verification
The bench fills every entry with distinct data and sweeps reads, translations, identifier-mismatch misses and probes over all of them. An off-by-one in the pointer decode or the match logic would therefore return another entry's frame number, or a false hit. The replacement pointer is followed through more than two full laps. A pointer that wraps at 7 or 0, or that starts from the wrong value, breaks the step-by-step comparison. A long burst of random writes must leave the reserved entries untouched. Duplicate matches, global entries, invalid entries, and stores to clean pages aim at a design that picks the higher match, ignores the global bit, or raises the wrong flag or more than one. A failing probe must keep the index value, so a design that clears that value on a miss is caught.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  parameter int VPN_W  = 20;
  parameter int PFN_W  = 20;
  parameter int ASID_W = 6;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
  } hi_t;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             nc;
    logic             dirty;
    logic             valid;
    logic             glob;
  } lo_t;

  typedef enum logic [1:0] {
    OP_RD     = 2'd0,
    OP_WR_IDX = 2'd1,
    OP_WR_RND = 2'd2,
    OP_PROBE  = 2'd3
  } op_e;
endpackage

// File: rtl/tlbx_first.sv
// Lowest-set-bit encoder: picks the winning entry among several matches.
module tlbx_first #(
  parameter int N = 64,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
  assign found = |vec;
endmodule

// File: rtl/tlbx_rand.sv
// Free-running replacement pointer, skipping the reserved low entries.
module tlbx_rand #(
  parameter int ENTRIES = 64,
  parameter int RSVD    = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] rnd_q
);
  localparam logic [IDX_W-1:0] TOP_V = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] LOW_V = IDX_W'(RSVD);

  logic [IDX_W-1:0] rnd_d;

  always_comb begin
    if (rnd_q == LOW_V) rnd_d = TOP_V;
    else                rnd_d = rnd_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd_q <= TOP_V;
    else        rnd_q <= rnd_d;
  end
endmodule

// File: rtl/tlbx_array.sv
// Entry storage with one write port, two read ports and two parallel match ports.
module tlbx_array
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  hi_t                wr_hi,
  input  lo_t                wr_lo,
  input  logic [IDX_W-1:0]   rd_idx,
  output hi_t                rd_hi,
  output lo_t                rd_lo,
  input  logic [IDX_W-1:0]   lk_idx,
  output lo_t                lk_lo,
  input  logic [VPN_W-1:0]   a_vpn,
  input  logic [ASID_W-1:0]  a_asid,
  output logic [ENTRIES-1:0] a_match,
  input  logic [VPN_W-1:0]   b_vpn,
  input  logic [ASID_W-1:0]  b_asid,
  output logic [ENTRIES-1:0] b_match
);
  hi_t ent_hi [ENTRIES];
  lo_t ent_lo [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    hi_t h_q;
    lo_t l_q;
    logic sel;

    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        h_q <= '0;
        l_q <= '0;
      end else if (sel) begin
        h_q <= wr_hi;
        l_q <= wr_lo;
      end
    end

    assign ent_hi[e]  = h_q;
    assign ent_lo[e]  = l_q;
    assign a_match[e] = (h_q.vpn == a_vpn) && (l_q.glob || (h_q.asid == a_asid));
    assign b_match[e] = (h_q.vpn == b_vpn) && (l_q.glob || (h_q.asid == b_asid));
  end

  assign rd_hi = ent_hi[rd_idx];
  assign rd_lo = ent_lo[rd_idx];
  assign lk_lo = ent_lo[lk_idx];
endmodule

// File: rtl/tlbx_top.sv
module tlbx_top
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int RSVD    = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stg_hi_we,
  input  logic [VPN_W-1:0]  stg_hi_vpn,
  input  logic [ASID_W-1:0] stg_hi_asid,
  input  logic              stg_lo_we,
  input  logic [PFN_W-1:0]  stg_lo_pfn,
  input  logic              stg_lo_nc,
  input  logic              stg_lo_dirty,
  input  logic              stg_lo_valid,
  input  logic              stg_lo_glob,
  input  logic              ptr_we,
  input  logic [IDX_W-1:0]  ptr_wdata,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_store,
  output logic [VPN_W-1:0]  hi_vpn_o,
  output logic [ASID_W-1:0] hi_asid_o,
  output logic [PFN_W-1:0]  lo_pfn_o,
  output logic              lo_nc_o,
  output logic              lo_dirty_o,
  output logic              lo_valid_o,
  output logic              lo_glob_o,
  output logic [IDX_W-1:0]  ptr_o,
  output logic              probe_fail_o,
  output logic [IDX_W-1:0]  rnd_o,
  output logic              rsp_valid_o,
  output logic [PFN_W-1:0]  rsp_pfn_o,
  output logic              rsp_nc_o,
  output logic              rsp_miss_o,
  output logic              rsp_inv_o,
  output logic              rsp_mod_o
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // operation decode
  op_e  op;
  logic do_rd, do_wr_idx, do_wr_rnd, do_probe;

  assign op        = op_e'(op_code);
  assign do_rd     = op_valid && (op == OP_RD);
  assign do_wr_idx = op_valid && (op == OP_WR_IDX);
  assign do_wr_rnd = op_valid && (op == OP_WR_RND);
  assign do_probe  = op_valid && (op == OP_PROBE);

  // control state
  hi_t              hi_q, hi_d;
  lo_t              lo_q, lo_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             pfail_q, pfail_d;
  logic [IDX_W-1:0] rnd_q;

  // array connections
  hi_t                rd_hi;
  lo_t                rd_lo, lk_lo;
  logic [ENTRIES-1:0] lk_match, pb_match;
  logic               lk_found, pb_found;
  logic [IDX_W-1:0]   lk_idx, pb_idx;

  tlbx_rand #(.ENTRIES(ENTRIES), .RSVD(RSVD)) rand_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .rnd_q (rnd_q)
  );

  tlbx_array #(.ENTRIES(ENTRIES)) array_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (do_wr_idx || do_wr_rnd),
    .wr_idx  (do_wr_rnd ? rnd_q : ptr_q),
    .wr_hi   (hi_q),
    .wr_lo   (lo_q),
    .rd_idx  (ptr_q),
    .rd_hi   (rd_hi),
    .rd_lo   (rd_lo),
    .lk_idx  (lk_idx),
    .lk_lo   (lk_lo),
    .a_vpn   (lk_vpn),
    .a_asid  (hi_q.asid),
    .a_match (lk_match),
    .b_vpn   (hi_q.vpn),
    .b_asid  (hi_q.asid),
    .b_match (pb_match)
  );

  tlbx_first #(.N(ENTRIES)) lk_first_i (
    .vec   (lk_match),
    .found (lk_found),
    .idx   (lk_idx)
  );

  tlbx_first #(.N(ENTRIES)) pb_first_i (
    .vec   (pb_match),
    .found (pb_found),
    .idx   (pb_idx)
  );

  // next state of the staging halves and the index pointer
  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (stg_hi_we) hi_d = '{vpn: stg_hi_vpn, asid: stg_hi_asid};
    if (stg_lo_we) lo_d = '{pfn: stg_lo_pfn, nc: stg_lo_nc, dirty: stg_lo_dirty,
                            valid: stg_lo_valid, glob: stg_lo_glob};
    if (do_rd) begin
      hi_d = rd_hi;
      lo_d = rd_lo;
    end
  end

  always_comb begin
    ptr_d   = ptr_q;
    pfail_d = pfail_q;
    if (ptr_we) begin
      ptr_d   = ptr_wdata;
      pfail_d = 1'b0;
    end
    if (do_probe) begin
      if (pb_found) begin
        ptr_d   = pb_idx;
        pfail_d = 1'b0;
      end else begin
        pfail_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      ptr_q   <= '0;
      pfail_q <= 1'b0;
    end else begin
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      ptr_q   <= ptr_d;
      pfail_q <= pfail_d;
    end
  end

  // translation response, one cycle after the request
  logic             rv_d, miss_d, inv_d, mod_d, nc_d;
  logic [PFN_W-1:0] pfn_d;
  logic             rv_q, miss_q, inv_q, mod_q, nc_q;
  logic [PFN_W-1:0] pfn_q;

  always_comb begin
    rv_d   = lk_valid;
    miss_d = lk_valid && !lk_found;
    inv_d  = lk_valid && lk_found && !lk_lo.valid;
    mod_d  = lk_valid && lk_found && lk_lo.valid && lk_store && !lk_lo.dirty;
    pfn_d  = (lk_valid && lk_found) ? lk_lo.pfn : '0;
    nc_d   = lk_valid && lk_found && lk_lo.nc;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rv_q   <= 1'b0;
      miss_q <= 1'b0;
      inv_q  <= 1'b0;
      mod_q  <= 1'b0;
      pfn_q  <= '0;
      nc_q   <= 1'b0;
    end else begin
      rv_q   <= rv_d;
      miss_q <= miss_d;
      inv_q  <= inv_d;
      mod_q  <= mod_d;
      pfn_q  <= pfn_d;
      nc_q   <= nc_d;
    end
  end

  assign hi_vpn_o     = hi_q.vpn;
  assign hi_asid_o    = hi_q.asid;
  assign lo_pfn_o     = lo_q.pfn;
  assign lo_nc_o      = lo_q.nc;
  assign lo_dirty_o   = lo_q.dirty;
  assign lo_valid_o   = lo_q.valid;
  assign lo_glob_o    = lo_q.glob;
  assign ptr_o        = ptr_q;
  assign probe_fail_o = pfail_q;
  assign rnd_o        = rnd_q;
  assign rsp_valid_o  = rv_q;
  assign rsp_pfn_o    = pfn_q;
  assign rsp_nc_o     = nc_q;
  assign rsp_miss_o   = miss_q;
  assign rsp_inv_o    = inv_q;
  assign rsp_mod_o    = mod_q;
endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk #(
  parameter int ENTRIES = 64,
  parameter int RSVD    = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] rnd,
  input logic             op_valid,
  input logic [1:0]       op_code,
  input logic             ptr_we,
  input logic [IDX_W-1:0] ptr_wdata,
  input logic [IDX_W-1:0] ptr,
  input logic             pfail,
  input logic             rsp_valid,
  input logic             miss,
  input logic             inv,
  input logic             modf
);
  localparam logic [IDX_W-1:0] TOP_V = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] LOW_V = IDX_W'(RSVD);

  assert_rnd_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rnd >= LOW_V);

  assert_rnd_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd == LOW_V) |=> (rnd == TOP_V));

  assert_rnd_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd != LOW_V) |=> (rnd == $past(rnd) - 1'b1));

  // R3, R8, R9: at most one response flag, and none without a response
  assert_flag_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({miss, inv, modf}));

  assert_flag_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(miss || inv || modf));

  assert_probe_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd3 && !ptr_we) |=> (!pfail || ptr == $past(ptr)));

  assert_ptr_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && !(op_valid && op_code == 2'd3)) |=> (!pfail && ptr == $past(ptr_wdata)));
endmodule

bind tlbx_top tlbx_chk #(.ENTRIES(ENTRIES), .RSVD(RSVD)) chk_i (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .rnd       (rnd_q),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .ptr_we    (ptr_we),
  .ptr_wdata (ptr_wdata),
  .ptr       (ptr_q),
  .pfail     (pfail_q),
  .rsp_valid (rv_q),
  .miss      (miss_q),
  .inv       (inv_q),
  .modf      (mod_q)
);

// File: tb/tlbx_top_tb_top.sv
module tlbx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stg_hi_we = 1'b0;
  logic [19:0] stg_hi_vpn = '0;
  logic [5:0]  stg_hi_asid = '0;
  logic        stg_lo_we = 1'b0;
  logic [19:0] stg_lo_pfn = '0;
  logic        stg_lo_nc = 1'b0, stg_lo_dirty = 1'b0, stg_lo_valid = 1'b0, stg_lo_glob = 1'b0;
  logic        ptr_we = 1'b0;
  logic [5:0]  ptr_wdata = '0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = '0;
  logic        lk_valid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic        lk_store = 1'b0;
  logic [19:0] hi_vpn_o, lo_pfn_o, rsp_pfn_o;
  logic [5:0]  hi_asid_o, ptr_o, rnd_o;
  logic        lo_nc_o, lo_dirty_o, lo_valid_o, lo_glob_o, probe_fail_o;
  logic        rsp_valid_o, rsp_nc_o, rsp_miss_o, rsp_inv_o, rsp_mod_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tlbx_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .stg_hi_we(stg_hi_we), .stg_hi_vpn(stg_hi_vpn), .stg_hi_asid(stg_hi_asid),
    .stg_lo_we(stg_lo_we), .stg_lo_pfn(stg_lo_pfn), .stg_lo_nc(stg_lo_nc),
    .stg_lo_dirty(stg_lo_dirty), .stg_lo_valid(stg_lo_valid), .stg_lo_glob(stg_lo_glob),
    .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .op_valid(op_valid), .op_code(op_code),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_store(lk_store),
    .hi_vpn_o(hi_vpn_o), .hi_asid_o(hi_asid_o), .lo_pfn_o(lo_pfn_o), .lo_nc_o(lo_nc_o),
    .lo_dirty_o(lo_dirty_o), .lo_valid_o(lo_valid_o), .lo_glob_o(lo_glob_o),
    .ptr_o(ptr_o), .probe_fail_o(probe_fail_o), .rnd_o(rnd_o),
    .rsp_valid_o(rsp_valid_o), .rsp_pfn_o(rsp_pfn_o), .rsp_nc_o(rsp_nc_o),
    .rsp_miss_o(rsp_miss_o), .rsp_inv_o(rsp_inv_o), .rsp_mod_o(rsp_mod_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] pfn_of(input int i);
    return 20'hA0000 + 20'(i * 257);
  endfunction

  task automatic stage(input logic [19:0] vpn, input logic [5:0] asid, input logic [19:0] pfn,
                       input logic nc, input logic d, input logic v, input logic g);
    stg_hi_we = 1'b1; stg_hi_vpn = vpn; stg_hi_asid = asid;
    stg_lo_we = 1'b1; stg_lo_pfn = pfn;
    stg_lo_nc = nc; stg_lo_dirty = d; stg_lo_valid = v; stg_lo_glob = g;
    @(negedge clk);
    stg_hi_we = 1'b0; stg_lo_we = 1'b0;
  endtask

  task automatic stage_asid(input logic [5:0] asid);
    stg_hi_we = 1'b1; stg_hi_vpn = 20'h7FFFF; stg_hi_asid = asid;
    @(negedge clk);
    stg_hi_we = 1'b0;
  endtask

  task automatic set_ptr(input int i);
    ptr_we = 1'b1; ptr_wdata = 6'(i);
    @(negedge clk);
    ptr_we = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] code);
    op_valid = 1'b1; op_code = code;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic write_entry(input int i, input logic [19:0] vpn, input logic [5:0] asid,
                             input logic [19:0] pfn, input logic nc, input logic d,
                             input logic v, input logic g);
    set_ptr(i);
    stage(vpn, asid, pfn, nc, d, v, g);
    do_op(2'd1);
  endtask

  task automatic lookup(input logic [19:0] vpn, input logic st);
    lk_valid = 1'b1; lk_vpn = vpn; lk_store = st;
    @(negedge clk);
    lk_valid = 1'b0; lk_store = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [5:0] exp_rnd;
    logic [5:0] r;
    // reset state
    repeat (3) @(negedge clk);
    check(rnd_o == 6'd63, "R4 rnd in reset", rnd_o, 63);
    check(ptr_o == 6'd0 && !probe_fail_o, "R10 ptr in reset", {probe_fail_o, ptr_o}, 0);
    check(!rsp_valid_o && !rsp_miss_o && !rsp_inv_o && !rsp_mod_o, "R3 flags in reset",
          {rsp_valid_o, rsp_miss_o, rsp_inv_o, rsp_mod_o}, 0);
    rst_n = 1'b1;

    // R4: two edges of reset release, then one step per clock
    exp_rnd = 6'd63;
    repeat (2) begin
      @(negedge clk);
      check(rnd_o == exp_rnd, "R4 hold during release", rnd_o, exp_rnd);
    end
    for (int k = 0; k < 130; k++) begin
      @(negedge clk);
      exp_rnd = (exp_rnd == 6'd8) ? 6'd63 : exp_rnd - 6'd1;
      check(rnd_o == exp_rnd, "R4 step", rnd_o, exp_rnd);
    end

    // R1: fill every entry, read each back
    for (int i = 0; i < 64; i++)
      write_entry(i, 20'h10000 | 20'(i), 6'(i), pfn_of(i), i[0], i[1], 1'b1, 1'b0);
    for (int i = 0; i < 64; i++) begin
      stage(20'h0, 6'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      set_ptr(i);
      do_op(2'd0);
      check(hi_vpn_o == (20'h10000 | 20'(i)) && hi_asid_o == 6'(i), "R1 read high",
            {hi_vpn_o, hi_asid_o}, {20'h10000 | 20'(i), 6'(i)});
      check(lo_pfn_o == pfn_of(i) && lo_nc_o == i[0] && lo_dirty_o == i[1] &&
            lo_valid_o && !lo_glob_o, "R1 read low",
            {lo_pfn_o, lo_nc_o, lo_dirty_o, lo_valid_o, lo_glob_o},
            {pfn_of(i), i[0], i[1], 1'b1, 1'b0});
    end

    // R2, R3, R9: hit with matching identifier, miss with another, store flags
    for (int i = 0; i < 64; i++) begin
      stage_asid(6'(i));
      lookup(20'h10000 | 20'(i), 1'b0);
      check(rsp_valid_o && !rsp_miss_o && !rsp_inv_o && !rsp_mod_o &&
            rsp_pfn_o == pfn_of(i) && rsp_nc_o == i[0], "R2 hit",
            {rsp_pfn_o, rsp_nc_o, rsp_miss_o}, {pfn_of(i), i[0], 1'b0});
      lookup(20'h10000 | 20'(i), 1'b1);
      check(rsp_mod_o == !i[1] && !rsp_miss_o && !rsp_inv_o, "R9 store modify flag",
            rsp_mod_o, !i[1]);
      stage_asid(6'(i + 1));
      lookup(20'h10000 | 20'(i), 1'b0);
      check(rsp_valid_o && rsp_miss_o && !rsp_inv_o && !rsp_mod_o, "R3 miss on identifier",
            {rsp_miss_o, rsp_inv_o, rsp_mod_o}, 3'b100);
    end
    lookup(20'h55555, 1'b1);
    check(rsp_miss_o && !rsp_mod_o, "R3 miss unknown page", {rsp_miss_o, rsp_mod_o}, 2'b10);

    // R6: probe finds every entry
    for (int i = 0; i < 64; i++) begin
      set_ptr((i + 17) % 64);
      stage(20'h10000 | 20'(i), 6'(i), 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      do_op(2'd3);
      check(ptr_o == 6'(i) && !probe_fail_o, "R6 probe hit", {probe_fail_o, ptr_o}, i);
    end

    // R7: failing probe keeps the index value; R10 clears the fail bit
    set_ptr(37);
    stage(20'h7FFFF, 6'd3, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_op(2'd3);
    check(probe_fail_o && ptr_o == 6'd37, "R7 probe miss", {probe_fail_o, ptr_o}, {1'b1, 6'd37});
    set_ptr(5);
    check(!probe_fail_o && ptr_o == 6'd5, "R10 pointer write", {probe_fail_o, ptr_o}, 5);

    // R8: invalid entry, load and store
    write_entry(20, 20'h10014, 6'd20, pfn_of(20), 1'b0, 1'b0, 1'b0, 1'b0);
    stage_asid(6'd20);
    lookup(20'h10014, 1'b0);
    check(rsp_inv_o && !rsp_miss_o && !rsp_mod_o, "R8 invalid load",
          {rsp_miss_o, rsp_inv_o, rsp_mod_o}, 3'b010);
    lookup(20'h10014, 1'b1);
    check(rsp_inv_o && !rsp_miss_o && !rsp_mod_o, "R8 invalid store",
          {rsp_miss_o, rsp_inv_o, rsp_mod_o}, 3'b010);
    // R6: probe ignores the valid bit
    stage(20'h10014, 6'd20, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_op(2'd3);
    check(ptr_o == 6'd20 && !probe_fail_o, "R6 probe invalid entry", ptr_o, 20);

    // R2: global entry matches any identifier
    write_entry(30, 20'h30030, 6'd1, 20'h12345, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int a = 0; a < 64; a += 9) begin
      stage_asid(6'(a));
      lookup(20'h30030, 1'b0);
      check(!rsp_miss_o && rsp_pfn_o == 20'h12345 && rsp_nc_o, "R2 global",
            rsp_pfn_o, 20'h12345);
    end

    // R2, R6: duplicate matches pick the lower entry
    write_entry(50, 20'h44444, 6'd9, 20'h00B50, 1'b0, 1'b1, 1'b1, 1'b0);
    write_entry(40, 20'h44444, 6'd9, 20'h00B40, 1'b0, 1'b1, 1'b1, 1'b0);
    stage_asid(6'd9);
    lookup(20'h44444, 1'b0);
    check(rsp_pfn_o == 20'h00B40, "R2 lowest match", rsp_pfn_o, 20'h00B40);
    stage(20'h44444, 6'd9, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_op(2'd3);
    check(ptr_o == 6'd40, "R6 lowest probe", ptr_o, 40);

    // R5: markers in the reserved entries, then random writes
    for (int i = 0; i < 8; i++)
      write_entry(i, 20'hC0000 | 20'(i), 6'd0, 20'hC0000 | 20'(i), 1'b0, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 12; k++) begin
      stage(20'hD0000 | 20'(k), 6'd2, 20'hE0000 | 20'(k), 1'b1, 1'b1, 1'b1, 1'b0);
      repeat (k) @(negedge clk);
      r = rnd_o;
      do_op(2'd2);
      set_ptr(int'(r));
      do_op(2'd0);
      check(hi_vpn_o == (20'hD0000 | 20'(k)) && lo_pfn_o == (20'hE0000 | 20'(k)),
            "R5 random slot", {hi_vpn_o, lo_pfn_o}, {20'hD0000 | 20'(k), 20'hE0000 | 20'(k)});
    end
    stage(20'hFFFFF, 6'd4, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 1'b1);
    op_valid = 1'b1; op_code = 2'd2;
    repeat (120) @(negedge clk);
    op_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      set_ptr(i);
      do_op(2'd0);
      check(hi_vpn_o == (20'hC0000 | 20'(i)) && lo_pfn_o == (20'hC0000 | 20'(i)),
            "R5 reserved untouched", hi_vpn_o, 20'hC0000 | 20'(i));
    end
    set_ptr(63);
    do_op(2'd0);
    check(hi_vpn_o == 20'hFFFFF, "R5 burst reached top", hi_vpn_o, 20'hFFFFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule